// File: doc/BRIEF.md
# Bounds Check Comparator with Flags

This block tests whether a register operand lies inside a pair of bounds and produces an updated five-bit condition flag vector. The operand size is byte, word or long. Narrow bounds are widened to 32 bits with their sign. A data-register operand is widened the same way, but an address-register operand is always compared over its full 32 bits.

The comparison takes two steps. The first step subtracts the lower bound from the operand and keeps only its zero result. The second step compares the bound span (upper minus lower) with the operand offset (operand minus lower). That step keeps both its zero result and its borrow. The new Z is the OR of the two zero results. The new C is the borrow of the second step. X, N and V pass through from the incoming flags. The caller presents a set of inputs with a valid strobe, and the updated flags appear one cycle later together with an output valid pulse.

Top module: `bounds_chk`

## Requirements
- R1: For byte (size code 00) and word (size code 01) sizes, both bounds are sign-extended from bit 7 or bit 15 respectively. Bound bits above the selected size have no effect on the result.
- R2: For a data-register operand (kind bit 0), the operand is sign-extended from the selected size, and its bits above that size have no effect. Size codes 10 and 11 both mean long, with no extension.
- R3: For an address-register operand (kind bit 1), all 32 operand bits are used unchanged, whatever the size.
- R4: Flag Z (bit 2) is 1 exactly when the widened operand equals the widened lower bound or the widened upper bound.
- R5: Flag C (bit 0) is 1 exactly when (operand - lower) modulo 2^32 is greater, as an unsigned number, than (upper - lower) modulo 2^32.
- R6: Flags X (bit 4), N (bit 3) and V (bit 1) equal the matching bits of the incoming flags.
- R7: flags_o and valid_o update on the clock edge after valid_i is sampled high. valid_o is high for exactly that one cycle, and flags_o holds its value while valid_i is low.
- R8: While reset is asserted and after it is released, flags_o is 0 and valid_o is 0 until the first strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Input strobe |
| size_i | input | 2 | 00 byte, 01 word, 10/11 long |
| addr_kind_i | input | 1 | 1 = address-register operand |
| value_i | input | 32 | Register operand |
| lower_i | input | 32 | Lower bound, low bits significant |
| upper_i | input | 32 | Upper bound, low bits significant |
| flags_i | input | 5 | Incoming flags {X,N,Z,V,C} |
| valid_o | output | 1 | Result strobe |
| flags_o | output | 5 | Updated flags {X,N,Z,V,C} |

## Verification
The hardest cases involve the neighbours of each bound after sign extension. Examples are an operand one below a negative byte bound, and a range whose span wraps past zero so that the lower bound is numerically above the upper one. Random values almost never land on these. The stimulus therefore builds the operand directly from each chosen bound (bound-1, bound, bound+1) for every size and both register kinds. It fills the unused high bits of bounds and operand with random garbage, and it includes inverted bound pairs.

// File: rtl/bchk_pkg.sv
package bchk_pkg;
  localparam int unsigned DW = 32;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned WORD_W = 16;
  localparam int unsigned FLAG_W = 5;
  localparam int unsigned F_C = 0;
  localparam int unsigned F_V = 1;
  localparam int unsigned F_Z = 2;
  localparam int unsigned F_N = 3;
  localparam int unsigned F_X = 4;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'b00,
    SZ_WORD = 2'b01,
    SZ_LONG = 2'b10,
    SZ_LALT = 2'b11
  } size_e;
endpackage

// File: rtl/bchk_sext.sv
module bchk_sext
  import bchk_pkg::*;
#(
  parameter int unsigned W  = DW,
  parameter int unsigned BW = BYTE_W,
  parameter int unsigned HW = WORD_W
) (
  input  logic [1:0]   size_i,
  input  logic         bypass_i,
  input  logic [W-1:0] raw_i,
  output logic [W-1:0] ext_o
);
  localparam int unsigned BPAD = W - BW;
  localparam int unsigned HPAD = W - HW;

  logic [W-1:0] ext_b, ext_h;
  assign ext_b = {{BPAD{raw_i[BW-1]}}, raw_i[BW-1:0]};
  assign ext_h = {{HPAD{raw_i[HW-1]}}, raw_i[HW-1:0]};

  always_comb begin
    if (bypass_i) ext_o = raw_i;
    else begin
      unique case (size_e'(size_i))
        SZ_BYTE: ext_o = ext_b;
        SZ_WORD: ext_o = ext_h;
        default: ext_o = raw_i;
      endcase
    end
  end

  // R1/R2: narrowed result must stay within signed range of its size
  always_comb begin
    if (!bypass_i && size_i == SZ_BYTE)
      a_byte_range_r1: assert (ext_o[W-1:BW-1] == '0 || ext_o[W-1:BW-1] == '1);
  end
endmodule

// File: rtl/bchk_cmp.sv
module bchk_cmp #(
  parameter int unsigned W = 32
) (
  input  logic [W-1:0] val_i,
  input  logic [W-1:0] lo_i,
  input  logic [W-1:0] hi_i,
  output logic         z_o,
  output logic         c_o
);
  logic [W-1:0] off, span;
  logic [W:0]   diff;
  logic         z_lo, z_hi;

  assign off  = val_i - lo_i;
  assign span = hi_i - lo_i;
  assign diff = {1'b0, span} - {1'b0, off};
  assign z_lo = (off == '0);
  assign z_hi = (span == off);
  assign z_o  = z_lo | z_hi;
  assign c_o  = diff[W];

  // R4/R5: single-point range that is not out of bounds must hit a bound
  always_comb begin
    if (lo_i == hi_i && !c_o)
      a_point_hit_r4: assert (z_o);
  end
endmodule

// File: rtl/bounds_chk.sv
module bounds_chk
  import bchk_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [1:0]        size_i,
  input  logic              addr_kind_i,
  input  logic [DW-1:0]     value_i,
  input  logic [DW-1:0]     lower_i,
  input  logic [DW-1:0]     upper_i,
  input  logic [FLAG_W-1:0] flags_i,
  output logic              valid_o,
  output logic [FLAG_W-1:0] flags_o
);
  logic [DW-1:0]     lo_x, hi_x, val_x;
  logic              z_n, c_n;
  logic [FLAG_W-1:0] flags_n;

  bchk_sext #(.W(DW)) u_ext_lo (.size_i(size_i), .bypass_i(1'b0), .raw_i(lower_i), .ext_o(lo_x));
  bchk_sext #(.W(DW)) u_ext_hi (.size_i(size_i), .bypass_i(1'b0), .raw_i(upper_i), .ext_o(hi_x));
  bchk_sext #(.W(DW)) u_ext_v  (.size_i(size_i), .bypass_i(addr_kind_i), .raw_i(value_i), .ext_o(val_x));

  bchk_cmp #(.W(DW)) u_cmp (.val_i(val_x), .lo_i(lo_x), .hi_i(hi_x), .z_o(z_n), .c_o(c_n));

  always_comb begin
    flags_n      = flags_i;
    flags_n[F_Z] = z_n;
    flags_n[F_C] = c_n;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      flags_o <= '0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) flags_o <= flags_n;
    end
  end

  p_strobe_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);
  p_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> (!valid_o && $stable(flags_o)));
  p_pass_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> (flags_o[F_X] == $past(flags_i[F_X]) && flags_o[F_N] == $past(flags_i[F_N])
                 && flags_o[F_V] == $past(flags_i[F_V])));
  p_addr_eq_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && addr_kind_i && size_i[1] && value_i == lower_i) |=> flags_o[F_Z]);
  p_point_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && addr_kind_i && size_i[1] && lower_i == upper_i)
      |=> (flags_o[F_C] == ($past(value_i) != $past(lower_i))));
endmodule

// File: tb/sim_bounds_chk.sv
`timescale 1ns/1ps
module sim_bounds_chk;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic [1:0]  size_i = '0;
  logic        addr_kind_i = 1'b0;
  logic [31:0] value_i = '0, lower_i = '0, upper_i = '0;
  logic [4:0]  flags_i = '0;
  logic        valid_o;
  logic [4:0]  flags_o;
  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #5 clk_i = ~clk_i;

  bounds_chk u0 (.*);

  function automatic logic [31:0] wid(input logic [31:0] x, input logic [1:0] sz);
    case (sz)
      2'b00: return {{24{x[7]}}, x[7:0]};
      2'b01: return {{16{x[15]}}, x[15:0]};
      default: return x;
    endcase
  endfunction

  function automatic logic [4:0] model(input logic [1:0] sz, input logic ak,
                                       input logic [31:0] v, lo, hi, input logic [4:0] fi);
    logic [31:0] ve, le, he;
    logic [4:0] r;
    le = wid(lo, sz); he = wid(hi, sz);
    ve = ak ? v : wid(v, sz);
    r = fi;
    r[2] = (ve == le) || (ve == he);
    r[0] = (ve - le) > (he - le);
    return r;
  endfunction

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  // drive at negedge, result registered at next posedge, sampled at following negedge
  task automatic run(input string tag, input logic [1:0] sz, input logic ak,
                     input logic [31:0] v, lo, hi, input logic [4:0] fi);
    @(negedge clk_i);
    size_i = sz; addr_kind_i = ak; value_i = v; lower_i = lo; upper_i = hi;
    flags_i = fi; valid_i = 1'b1;
    @(negedge clk_i);
    valid_i = 1'b0;
    chk({tag, " R7 valid"}, {31'd0, valid_o}, 32'd1);
    chk(tag, {27'd0, flags_o}, {27'd0, model(sz, ak, v, lo, hi, fi)});
  endtask

  function automatic logic [31:0] mix(input logic [31:0] bnd, input logic [1:0] sz);
    logic [31:0] g;
    g = $urandom;
    case (sz)
      2'b00: return {g[31:8], bnd[7:0]};
      2'b01: return {g[31:16], bnd[15:0]};
      default: return bnd;
    endcase
  endfunction

  initial begin
    #2_000_000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [4:0] held;
    void'($urandom(32'd2024));
    #23;
    chk("R8 reset valid", {31'd0, valid_o}, 32'd0);
    chk("R8 reset flags", {27'd0, flags_o}, 32'd0);
    rst_ni = 1'b1;
    @(negedge clk_i); @(negedge clk_i);
    chk("R8 post-reset flags", {27'd0, flags_o}, 32'd0);

    // R1 R2 R3 R4 R5: bound neighbours, all sizes and kinds
    for (int sz = 0; sz < 3; sz++) begin
      for (int ak = 0; ak < 2; ak++) begin
        for (int pr = 0; pr < 4; pr++) begin
          logic [31:0] lo, hi, bnd, v;
          case (pr)
            0: begin lo = 32'hFFFF_FF90; hi = 32'h0000_0020; end
            1: begin lo = 32'h0000_0005; hi = 32'h0000_0060; end
            2: begin lo = 32'h0000_0010; hi = 32'hFFFF_FFF0; end
            default: begin lo = 32'h0000_7F00; hi = 32'hFFFF_8100; end
          endcase
          for (int b = 0; b < 2; b++) begin
            bnd = b ? hi : lo;
            for (int d = -1; d <= 1; d++) begin
              v = wid(bnd, 2'(sz)) + 32'(d);
              if (ak == 0) v = mix(v, 2'(sz));
              run(ak ? "R3 R4 R5 addr bound" : "R1 R2 R4 R5 data bound",
                  2'(sz), 1'(ak), v, mix(lo, 2'(sz)), mix(hi, 2'(sz)), 5'($urandom));
            end
          end
        end
      end
    end

    // R2: size code 11 acts as long
    run("R2 alt long", 2'b11, 1'b0, 32'h8000_0000, 32'h7FFF_FFFF, 32'h8000_0001, 5'h1A);
    // R3: address operand not narrowed even for byte size
    run("R3 addr byte", 2'b00, 1'b1, 32'h0000_0105, 32'hAB00_0001, 32'h0000_0010, 5'h00);
    // R6: pass-through of X N V
    run("R6 passthrough", 2'b10, 1'b1, 32'd5, 32'd5, 32'd9, 5'h1F);
    run("R6 passthrough zero", 2'b10, 1'b1, 32'd50, 32'd5, 32'd9, 5'h00);

    // R7: hold while valid_i low
    held = flags_o;
    @(negedge clk_i);
    value_i = 32'h1234; lower_i = 32'h9999; upper_i = 32'h0; flags_i = ~flags_i;
    @(negedge clk_i); @(negedge clk_i);
    chk("R7 hold flags", {27'd0, flags_o}, {27'd0, held});
    chk("R7 no strobe", {31'd0, valid_o}, 32'd0);

    // random mix
    for (int i = 0; i < 400; i++) begin
      logic [31:0] lo, hi;
      lo = $urandom; hi = $urandom;
      run("R1 R2 R3 R4 R5 R6 random", 2'($urandom), 1'($urandom),
          ($urandom % 4 == 0) ? hi : $urandom, lo, hi, 5'($urandom));
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule